// File: doc/BRIEF.md
# Register-Mapped Serial Port

This block is a byte-oriented asynchronous serial port that software drives through a small set of 32-bit registers. Outgoing bytes go into a transmit queue and are shifted out on `txd` as frames with one start bit, eight data bits (least significant first), no parity and one stop bit. Incoming frames on `rxd` are found by their falling start edge, sampled near the middle of each bit, and collected in a receive queue. One data register serves both directions: a write appends to the transmit queue and a read takes the oldest received byte.

The bit time is set by two registers. A 16-bit prescale value gives the number of clocks per sample tick, and an 8-bit value N gives N+1 sample ticks per bit, so one bit lasts prescale*(N+1) clocks. A control register holds separate enables for the two directions and two flush pulses, one for each direction, that clear themselves. A status register reports an empty receive queue, a full transmit queue and a transmitter still busy. Software polls these flags before each access.

Top module: `mmio_uart`

## Requirements
- R1: After reset, control reads 0, status reads 0x2 (receive queue empty), the prescale and bit-length registers read their reset parameters, and `txd` is high.
- R2: Word index `addr[5:2]` selects the register: 0 control, 1 mode (11 bits, stored and read back), 6 prescale (16 bits), 11 status (bits 1, 4 and 11 carry flags, the rest read 0), 12 data, 13 bit length (8 bits). Other indices read 0 and ignore writes, and writes to status have no effect. Read data appears on `rdata` one clock after `rd_en`.
- R3: Control bit 2 enables the receiver and bit 4 enables the transmitter. Control bits 0 (receive flush) and 1 (transmit flush) clear themselves on the clock after the write, so a later read of control shows them as 0.
- R4: Each transmitted frame is a low start bit, the eight data bits with the least significant first, and a high stop bit. Data and stop bits last prescale*(N+1) clocks each, and the start bit is shortened by at most one prescale period.
- R5: The transmit queue holds DEPTH bytes (default 16). Status bit 4 is set while it holds DEPTH bytes, and a data write to a full queue is dropped.
- R6: Status bit 11 rises with the first start bit and stays high across back-to-back frames, with no idle gap between them, until the stop bit of the last queued byte ends.
- R7: With the transmitter disabled, written bytes stay queued, no frame starts and `txd` stays high.
- R8: With the receiver enabled, each frame with a high stop bit pushes its byte into the receive queue in order of arrival. Status bit 1 is cleared while the queue holds data, and each data read returns and removes the oldest byte.
- R9: A data read while the receive queue is empty returns 0.
- R10: With the receiver disabled, incoming frames are ignored and the receive queue stays empty.
- R11: The transmit flush empties the transmit queue, aborts any frame in progress (`txd` high, bit 11 clear). The receive flush empties the receive queue.
- R12: When the receive queue already holds DEPTH bytes, a further received byte is dropped and the queued bytes are kept.
- R13: A low pulse on `rxd` that is high again at the middle of the start bit is rejected as noise, and the receiver still accepts the next valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset; bits 5:2 select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The bench builds the block with DEPTH=4, so that a full transmit queue, a dropped fifth write and a receive overflow each take only a few frames. The prescale and bit-length reset values are 3 and 4, and the bench then programs a prescale of 2. That gives ten clocks per bit, which keeps each frame at about a hundred cycles. With these values the bench checks the middle of every bit on `txd`, checks the gap between back-to-back frames, and runs flushes in the middle of a frame, all well inside the run limit.

// File: rtl/mmio_uart.sv
module mmio_uart #(
  parameter int DEPTH = 16,
  parameter logic [15:0] BGEN_RST = 16'd54,
  parameter logic [7:0] BDIV_RST = 8'd15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        txd,
  input  logic        rxd
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [3:0] wa;
  assign wa = addr[5:2];
  logic ctrl_wr, data_wr, data_rd;
  assign ctrl_wr = wr_en && wa == 4'd0;
  assign data_wr = wr_en && wa == 4'd12;
  assign data_rd = rd_en && wa == 4'd12;

  logic unused_ok;
  assign unused_ok = ^{wdata[31:16], addr[1:0]};

  logic rx_en, tx_en, txrst_p, rxrst_p;
  logic [10:0] mode_q;
  logic [15:0] bgen_q;
  logic [7:0]  bdiv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0; tx_en <= 1'b0; txrst_p <= 1'b0; rxrst_p <= 1'b0;
      mode_q <= '0; bgen_q <= BGEN_RST; bdiv_q <= BDIV_RST;
    end else begin
      txrst_p <= 1'b0;
      rxrst_p <= 1'b0;
      if (ctrl_wr) begin
        rxrst_p <= wdata[0];
        txrst_p <= wdata[1];
        rx_en   <= wdata[2];
        tx_en   <= wdata[4];
      end
      if (wr_en && wa == 4'd1)  mode_q <= wdata[10:0];
      if (wr_en && wa == 4'd6)  bgen_q <= wdata[15:0];
      if (wr_en && wa == 4'd13) bdiv_q <= wdata[7:0];
    end
  end

  logic [15:0] bcnt;
  logic tick;
  assign tick = (bgen_q == 16'd0) || (bcnt >= bgen_q - 16'd1);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else bcnt <= tick ? '0 : bcnt + 16'd1;

  // transmit queue and shifter
  logic [7:0] tx_mem [DEPTH];
  logic [CW-1:0] tx_wp, tx_rp, tx_cnt;
  logic tx_full, tx_empty, tx_push, tx_load, tx_end, tx_busy;
  logic [9:0] tx_sh;
  logic [3:0] tx_bit;
  logic [7:0] tx_sc;

  assign tx_cnt   = tx_wp - tx_rp;
  assign tx_full  = tx_cnt == CW'(DEPTH);
  assign tx_empty = tx_cnt == '0;
  assign tx_push  = data_wr && !tx_full && !txrst_p;
  assign tx_end   = tx_busy && tick && tx_sc == bdiv_q && tx_bit == 4'd9;
  assign tx_load  = tx_en && !tx_empty && !txrst_p && (!tx_busy || tx_end);
  assign txd      = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0;
    end else if (txrst_p) begin
      tx_wp <= '0; tx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + CW'(1);
      if (tx_load) tx_rp <= tx_rp + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_bit <= '0; tx_sc <= '0;
    end else if (txrst_p) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_bit <= '0; tx_sc <= '0;
    end else if (tx_load) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, tx_mem[tx_rp[AW-1:0]], 1'b0};
      tx_bit  <= '0;
      tx_sc   <= '0;
    end else if (tx_busy && tick) begin
      if (tx_sc == bdiv_q) begin
        tx_sc  <= '0;
        tx_bit <= tx_bit + 4'd1;
        tx_sh  <= {1'b1, tx_sh[9:1]};
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
      end else begin
        tx_sc <= tx_sc + 8'd1;
      end
    end
  end

  // receive sampler and queue
  logic rx_s1, rx_s2, rx_prev, rx_busy, rx_mid;
  logic [3:0] rx_bit;
  logic [7:0] rx_sc, rx_sh;
  logic [7:0] rx_mem [DEPTH];
  logic [CW-1:0] rx_wp, rx_rp, rx_cnt;
  logic rx_full, rx_empty, rx_push, rx_pop;

  assign rx_cnt   = rx_wp - rx_rp;
  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign rx_empty = rx_cnt == '0;
  assign rx_mid   = rx_busy && tick && rx_sc == (bdiv_q >> 1);
  assign rx_push  = rx_mid && rx_bit == 4'd9 && rx_s2 && !rx_full && !rxrst_p;
  assign rx_pop   = data_rd && !rx_empty && !rxrst_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1; rx_prev <= 1'b1;
    end else begin
      rx_s1 <= rxd; rx_s2 <= rx_s1; rx_prev <= rx_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_bit <= '0; rx_sc <= '0; rx_sh <= '0;
    end else if (rxrst_p || !rx_en) begin
      rx_busy <= 1'b0; rx_bit <= '0; rx_sc <= '0;
    end else if (!rx_busy) begin
      if (rx_prev && !rx_s2) begin
        rx_busy <= 1'b1; rx_bit <= '0; rx_sc <= '0;
      end
    end else if (tick) begin
      if (rx_mid) begin
        if (rx_bit == 4'd0 && rx_s2) rx_busy <= 1'b0;
        if (rx_bit >= 4'd1 && rx_bit <= 4'd8) rx_sh <= {rx_s2, rx_sh[7:1]};
        if (rx_bit == 4'd9) rx_busy <= 1'b0;
      end
      if (rx_sc == bdiv_q) begin
        rx_sc  <= '0;
        rx_bit <= rx_bit + 4'd1;
      end else begin
        rx_sc <= rx_sc + 8'd1;
      end
    end
  end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0;
    end else if (rxrst_p) begin
      rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + CW'(1);
      if (rx_pop)  rx_rp <= rx_rp + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (wa)
        4'd0:  rdata <= {27'b0, tx_en, 1'b0, rx_en, txrst_p, rxrst_p};
        4'd1:  rdata <= {21'b0, mode_q};
        4'd6:  rdata <= {16'b0, bgen_q};
        4'd11: rdata <= {20'b0, tx_busy, 6'b0, tx_full, 2'b0, rx_empty, 1'b0};
        4'd12: rdata <= rx_pop ? {24'b0, rx_mem[rx_rp[AW-1:0]]} : 32'b0;
        4'd13: rdata <= {24'b0, bdiv_q};
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_uart_checker.sv
module mmio_uart_checker #(
  parameter int CW = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          ctrl_wr,
  input logic          txrst_p,
  input logic          rxrst_p,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  p_tx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  p_rx_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  p_txrst_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txrst_p && !ctrl_wr |=> !txrst_p);

  p_rxrst_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rxrst_p && !ctrl_wr |=> !rxrst_p);

  p_tx_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    txrst_p |=> tx_cnt == '0 && txd);

  p_rx_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rxrst_p |=> rx_cnt == '0);
endmodule

bind mmio_uart mmio_uart_checker #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .ctrl_wr(ctrl_wr),
  .txrst_p(txrst_p), .rxrst_p(rxrst_p), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/mmio_uart_tb.sv
module mmio_uart_tb;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic txd;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  mmio_uart #(.DEPTH(DEPTH), .BGEN_RST(16'd3), .BDIV_RST(8'd4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for a start edge on txd, then samples each bit at its middle
  task automatic get_frame(output logic [7:0] b, output int waited);
    waited = 0;
    while (txd && waited < 400) begin @(negedge clk); waited++; end
    chk("R4 start seen", {31'b0, txd}, 32'h0);
    idle(5);
    chk("R4 start bit", {31'b0, txd}, 32'h0);
    for (int i = 0; i < 8; i++) begin idle(10); b[i] = txd; end
    idle(10);
    chk("R4 stop bit", {31'b0, txd}, 32'h1);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rxd = 1'b0; idle(10);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; idle(10); end
    rxd = 1'b1; idle(10);
  endtask

  task automatic no_frame(input string req, input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!txd) lows++; end
    chk(req, lows, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 txd idle", {31'b0, txd}, 32'h1);
    rd(6'h00, d); chk("R1 control", d, 32'h0);
    rd(6'h2C, d); chk("R1 status", d, 32'h2);
    rd(6'h18, d); chk("R1 prescale", d, 32'h3);
    rd(6'h34, d); chk("R1 bit length", d, 32'h4);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, d); chk("R2 mode width", d, 32'h7FF);
    wr(6'h04, 32'h20); rd(6'h04, d); chk("R2 mode", d, 32'h20);
    wr(6'h18, 32'hABCD_0002); rd(6'h18, d); chk("R2 prescale", d, 32'h2);
    wr(6'h34, 32'h0000_0104); rd(6'h34, d); chk("R2 bit length", d, 32'h4);
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, d); chk("R2 hole reads 0", d, 32'h0);
    rd(6'h3C, d); chk("R2 beyond map", d, 32'h0);
    wr(6'h2C, 32'hFFFF_FFFF); rd(6'h2C, d); chk("R2 status write ignored", d, 32'h2);
    rd(6'h00, d); chk("R2 control untouched", d, 32'h0);
  endtask

  task automatic t_selfclear;
    logic [31:0] d;
    wr(6'h00, 32'h17); rd(6'h00, d); chk("R3 flush bits clear", d, 32'h14);
  endtask

  task automatic t_tx_basic;
    logic [7:0] b; int w; logic [31:0] d;
    wr(6'h30, 32'h1234_56A5);
    get_frame(b, w); chk("R4 byte A5", {24'b0, b}, 32'hA5);
    idle(20); rd(6'h2C, d); chk("R6 idle after frame", d, 32'h2);
  endtask

  task automatic t_tx_disabled_and_burst;
    logic [7:0] b; int w; logic [31:0] d;
    wr(6'h00, 32'h04);
    wr(6'h30, 32'h11); wr(6'h30, 32'h22); wr(6'h30, 32'h33);
    no_frame("R7 no frame while disabled", 300);
    rd(6'h2C, d); chk("R7 queued not active", d, 32'h2);
    wr(6'h00, 32'h14);
    get_frame(b, w); chk("R6 burst byte 0", {24'b0, b}, 32'h11);
    get_frame(b, w); chk("R6 burst byte 1", {24'b0, b}, 32'h22);
    chk("R6 no gap", (w <= 6) ? 32'h1 : 32'h0, 32'h1);
    get_frame(b, w); chk("R6 burst byte 2", {24'b0, b}, 32'h33);
    rd(6'h2C, d); chk("R6 active in last stop", d, 32'h802);
    idle(20); rd(6'h2C, d); chk("R6 drops after last stop", d, 32'h2);
  endtask

  task automatic t_tx_full;
    logic [7:0] b; int w; logic [31:0] d;
    wr(6'h00, 32'h04);
    for (int i = 0; i < DEPTH; i++) wr(6'h30, 32'h40 + i);
    rd(6'h2C, d); chk("R5 full flag", d, 32'h12);
    wr(6'h30, 32'hEE);
    wr(6'h00, 32'h14);
    for (int i = 0; i < DEPTH; i++) begin
      get_frame(b, w); chk("R5 queued order", {24'b0, b}, 32'h40 + i);
    end
    no_frame("R5 write to full dropped", 150);
  endtask

  task automatic t_tx_flush;
    logic [31:0] d;
    wr(6'h00, 32'h04);
    wr(6'h30, 32'h5A); wr(6'h30, 32'h6B);
    wr(6'h00, 32'h14);
    idle(30);
    wr(6'h00, 32'h16);
    idle(1);
    chk("R11 txd high after flush", {31'b0, txd}, 32'h1);
    rd(6'h2C, d); chk("R11 tx status after flush", d, 32'h2);
    no_frame("R11 queue emptied", 150);
    rd(6'h00, d); chk("R11 control after flush", d, 32'h14);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    send(8'h3C); send(8'hC3);
    rd(6'h2C, d); chk("R8 not empty", d, 32'h0);
    rd(6'h30, d); chk("R8 first byte", d, 32'h3C);
    rd(6'h30, d); chk("R8 second byte", d, 32'hC3);
    rd(6'h2C, d); chk("R8 empty again", d, 32'h2);
    rd(6'h30, d); chk("R9 empty read zero", d, 32'h0);
  endtask

  task automatic t_rx_disabled;
    logic [31:0] d;
    wr(6'h00, 32'h10);
    send(8'h55);
    rd(6'h2C, d); chk("R10 frame ignored", d, 32'h2);
    rd(6'h30, d); chk("R10 nothing queued", d, 32'h0);
    wr(6'h00, 32'h14);
  endtask

  task automatic t_rx_overflow;
    logic [31:0] d;
    for (int i = 0; i <= DEPTH; i++) send(8'h90 + 8'(i));
    for (int i = 0; i < DEPTH; i++) begin
      rd(6'h30, d); chk("R12 kept bytes", d, 32'h90 + i);
    end
    rd(6'h30, d); chk("R12 extra byte dropped", d, 32'h0);
  endtask

  task automatic t_rx_flush;
    logic [31:0] d;
    send(8'h01); send(8'h02);
    wr(6'h00, 32'h15);
    rd(6'h2C, d); chk("R11 rx flushed", d, 32'h2);
    rd(6'h30, d); chk("R11 rx read after flush", d, 32'h0);
  endtask

  task automatic t_glitch;
    logic [31:0] d;
    @(negedge clk); rxd = 1'b0; idle(2); rxd = 1'b1;
    idle(120);
    rd(6'h2C, d); chk("R13 glitch rejected", d, 32'h2);
    send(8'h81);
    rd(6'h30, d); chk("R13 next frame received", d, 32'h81);
  endtask

  task automatic run_all;
    idle(3); rst_n = 1'b1; idle(2);
    t_reset();
    t_regs();
    t_selfclear();
    t_tx_basic();
    t_tx_disabled_and_burst();
    t_tx_full();
    t_tx_flush();
    t_rx_basic();
    t_rx_disabled();
    t_rx_overflow();
    t_rx_flush();
    t_glitch();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule